// File: doc/BRIEF.md
# Interrupt Pin Request and In-Service Tracker

This block holds the pending-request and in-service state of a bank of interrupt pins (24 by default) and turns that state into an ordered stream of pins for a downstream delivery stage. Requests arrive in three ways: a single-pin level update that honours each pin's trigger type, a bulk OR mask, and a bulk clear mask. Per-pin routing fields come in from a separate register block as flat vectors: a delivery vector, a mask bit and a level/edge trigger bit for each pin.

Every cycle the tracker takes the highest-numbered pin that is pending and not in service. An unmasked pin is offered to the delivery stage through a valid/ready handshake. A masked pin is dropped. Either way, completing the service clears the pin's request. A level-triggered pin also enters service and is held back from further offers until an end-of-interrupt names its vector. Ignored end-of-interrupts and stale ones are reported as one-cycle flags. The bad-pin-index report works the same way.

Top module: `pin_req_tracker`

## Requirements
- R1: A single-pin update (`upd_valid`) changes nothing when `ctl_enable` is low or the addressed pin's `cfg_mask` bit is 1.
- R2: A single-pin update whose index is 24 or more changes no state, and it raises `pin_err` for exactly the following cycle. `pin_err` is low otherwise.
- R3: On a single-pin update to a pin whose `cfg_level` bit is 1, the request bit takes the value of `upd_level`. On a pin whose `cfg_level` bit is 0, `upd_level`=1 sets the request bit and `upd_level`=0 leaves it unchanged.
- R4: `bset_mask` bit i sets request bit i, and `bclr_mask` bit i clears request bit i, for i in 0..15. Both apply regardless of `ctl_enable` and `cfg_mask`.
- R5: While any pin has request=1 and in-service=0, the highest such pin is the candidate. If the candidate is unmasked, `dlv_valid` is high with `dlv_pin` equal to that pin, `dlv_vector` equal to bits [8p+7:8p] of `cfg_vector` and `dlv_level` equal to its `cfg_level` bit. At most one pin is offered per cycle.
- R6: A candidate completes service on a cycle where it is masked, or where it is unmasked and `dlv_ready` is high. Completion clears its request bit, and sets its in-service bit when its `cfg_level` bit is 1. A masked candidate is never offered.
- R7: A pin whose in-service bit is 1 is never offered.
- R8: An end-of-interrupt (`eoi_valid` with `eoi_vector`) finds the lowest pin index among 0..22 whose vector field equals `eoi_vector`. Pin 23 is never searched. The in-service bit of that pin is cleared.
- R9: In the cycle after an end-of-interrupt, `eoi_nomatch` is high if no pin among 0..22 matched. `eoi_stale` is high if the matched pin's in-service bit was already 0. The two are never high together.
- R10: Within one cycle the request vector is updated in this order: service completion clear, bulk set, bulk clear, then the single-pin update. For in-service, the end-of-interrupt clear precedes the service set.
- R11: After reset the request and in-service vectors are zero, `dlv_valid` is low and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released upstream |
| ctl_enable | input | 1 | Controller enable for single-pin updates |
| cfg_vector | input | 192 | Per-pin delivery vector, 8 bits per pin, pin p at [8p+7:8p] |
| cfg_mask | input | 24 | Per-pin mask, 1 = masked |
| cfg_level | input | 24 | Per-pin trigger, 1 = level, 0 = edge |
| upd_valid | input | 1 | Single-pin update strobe |
| upd_idx | input | 5 | Single-pin update index |
| upd_level | input | 1 | Single-pin input level |
| bset_valid | input | 1 | Bulk set strobe |
| bset_mask | input | 16 | Bulk set mask for pins 0..15 |
| bclr_valid | input | 1 | Bulk clear strobe |
| bclr_mask | input | 16 | Bulk clear mask for pins 0..15 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | End-of-interrupt vector |
| dlv_ready | input | 1 | Delivery stage accepts the offered pin |
| dlv_valid | output | 1 | A pin is offered for delivery |
| dlv_pin | output | 5 | Offered pin index |
| dlv_vector | output | 8 | Vector of the offered pin |
| dlv_level | output | 1 | Trigger type of the offered pin |
| req_vec | output | 24 | Current request vector |
| isr_vec | output | 24 | Current in-service vector |
| pin_err | output | 1 | Out-of-range single-pin index seen last cycle |
| eoi_nomatch | output | 1 | Last cycle's end-of-interrupt matched no pin |
| eoi_stale | output | 1 | Last cycle's end-of-interrupt hit a pin not in service |

## Verification
Several properties are checked every cycle. An offered pin is always pending, out of service, unmasked and the highest such pin. An accepted level-triggered offer shows in service on the next cycle. A bad index is always flagged. The two end-of-interrupt flags never coincide. Other behaviour depends on particular stimulus and is covered by the bench scenarios: the same-cycle update order, edge requests surviving a low input, updates ignored while disabled or masked, the first-match search that excludes pin 23, and masked candidates dropped silently. A cycle-level reference model in the bench follows all of these under random traffic.

// File: rtl/pin_trk_pkg.sv
`timescale 1ns/1ps
package pin_trk_pkg;

  typedef enum logic [1:0] {
    EOI_IDLE    = 2'd0,
    EOI_HIT     = 2'd1,
    EOI_NOMATCH = 2'd2,
    EOI_STALE   = 2'd3
  } eoi_res_t;

  typedef struct packed {
    logic bad_pin;
    logic eoi_nomatch;
    logic eoi_stale;
  } trk_flags_t;

endpackage

// File: rtl/trk_hi_pick.sv
`timescale 1ns/1ps
// Highest-index set bit of a vector.
module trk_hi_pick #(
  parameter int W     = 24,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     cand,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/trk_req_next.sv
`timescale 1ns/1ps
// Next request vector: service clear, bulk set, bulk clear, single pin.
module trk_req_next #(
  parameter int NUM_PINS = 24,
  parameter int BULK_W   = 16,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] req_cur,
  input  logic [NUM_PINS-1:0] svc_clr,
  input  logic                set_valid,
  input  logic [BULK_W-1:0]   set_mask,
  input  logic                clr_valid,
  input  logic [BULK_W-1:0]   clr_mask,
  input  logic                enable,
  input  logic [NUM_PINS-1:0] pin_mask,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic                upd_valid,
  input  logic [IDX_W-1:0]    upd_idx,
  input  logic                upd_level,
  output logic [NUM_PINS-1:0] req_nxt,
  output logic                bad_pin
);

  localparam logic [IDX_W:0] PIN_LIMIT = (IDX_W+1)'(NUM_PINS);

  logic [NUM_PINS-1:0] set_ext;
  logic [NUM_PINS-1:0] clr_ext;

  generate
    if (BULK_W < NUM_PINS) begin : g_pad
      assign set_ext = {{(NUM_PINS-BULK_W){1'b0}}, set_mask};
      assign clr_ext = {{(NUM_PINS-BULK_W){1'b0}}, clr_mask};
    end else begin : g_trim
      assign set_ext = set_mask[NUM_PINS-1:0];
      assign clr_ext = clr_mask[NUM_PINS-1:0];
    end
  endgenerate

  always_comb begin
    req_nxt = req_cur & ~svc_clr;
    if (set_valid) req_nxt = req_nxt | set_ext;
    if (clr_valid) req_nxt = req_nxt & ~clr_ext;
    bad_pin = upd_valid && ({1'b0, upd_idx} >= PIN_LIMIT);
    if (upd_valid && !bad_pin && enable && !pin_mask[upd_idx]) begin
      if (pin_level[upd_idx])
        req_nxt[upd_idx] = upd_level;
      else if (upd_level)
        req_nxt[upd_idx] = 1'b1;
    end
  end

endmodule

// File: rtl/trk_eoi_match.sv
`timescale 1ns/1ps
// End-of-interrupt lookup: lowest index in 0..NUM_PINS-2 whose vector matches.
module trk_eoi_match
  import pin_trk_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8
) (
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vector,
  input  logic [NUM_PINS-1:0]       isr_cur,
  output logic [NUM_PINS-1:0]       isr_clr,
  output eoi_res_t                  res
);

  logic [NUM_PINS-1:0] first_hit;
  logic                any_hit;

  always_comb begin
    first_hit = '0;
    any_hit   = 1'b0;
    for (int i = NUM_PINS-2; i >= 0; i--) begin
      if (cfg_vector[i*VEC_W +: VEC_W] == eoi_vector) begin
        first_hit    = '0;
        first_hit[i] = 1'b1;
        any_hit      = 1'b1;
      end
    end
  end

  always_comb begin
    isr_clr = '0;
    res     = EOI_IDLE;
    if (eoi_valid) begin
      if (!any_hit) begin
        res = EOI_NOMATCH;
      end else if ((first_hit & isr_cur) == '0) begin
        res = EOI_STALE;
      end else begin
        res     = EOI_HIT;
        isr_clr = first_hit;
      end
    end
  end

endmodule

// File: rtl/pin_req_tracker.sv
`timescale 1ns/1ps
module pin_req_tracker
  import pin_trk_pkg::*;
#(
  parameter  int NUM_PINS = 24,
  parameter  int BULK_W   = 16,
  parameter  int VEC_W    = 8,
  localparam int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctl_enable,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vector,
  input  logic [NUM_PINS-1:0]       cfg_mask,
  input  logic [NUM_PINS-1:0]       cfg_level,
  input  logic                      upd_valid,
  input  logic [IDX_W-1:0]          upd_idx,
  input  logic                      upd_level,
  input  logic                      bset_valid,
  input  logic [BULK_W-1:0]         bset_mask,
  input  logic                      bclr_valid,
  input  logic [BULK_W-1:0]         bclr_mask,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic                      dlv_ready,
  output logic                      dlv_valid,
  output logic [IDX_W-1:0]          dlv_pin,
  output logic [VEC_W-1:0]          dlv_vector,
  output logic                      dlv_level,
  output logic [NUM_PINS-1:0]       req_vec,
  output logic [NUM_PINS-1:0]       isr_vec,
  output logic                      pin_err,
  output logic                      eoi_nomatch,
  output logic                      eoi_stale
);

  logic [NUM_PINS-1:0] req_q, req_nxt;
  logic [NUM_PINS-1:0] isr_q, isr_nxt;
  trk_flags_t          flags_q, flags_nxt;

  logic [NUM_PINS-1:0] cand;
  logic                cand_any;
  logic [IDX_W-1:0]    sel;
  logic                sel_masked;
  logic                svc_done;
  logic [NUM_PINS-1:0] svc_onehot;
  logic [NUM_PINS-1:0] eoi_clr;
  eoi_res_t            eoi_res;
  logic                bad_pin;
  logic                req_we;
  logic                isr_we;

  // candidate selection
  assign cand = req_q & ~isr_q;

  trk_hi_pick #(.W(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .cand (cand),
    .any  (cand_any),
    .idx  (sel)
  );

  assign sel_masked = cfg_mask[sel];
  assign svc_done   = cand_any && (sel_masked || dlv_ready);

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_svc
      assign svc_onehot[g] = svc_done && (sel == IDX_W'(g));
    end
  endgenerate

  // request vector next state
  trk_req_next #(.NUM_PINS(NUM_PINS), .BULK_W(BULK_W), .IDX_W(IDX_W)) u_req (
    .req_cur   (req_q),
    .svc_clr   (svc_onehot),
    .set_valid (bset_valid),
    .set_mask  (bset_mask),
    .clr_valid (bclr_valid),
    .clr_mask  (bclr_mask),
    .enable    (ctl_enable),
    .pin_mask  (cfg_mask),
    .pin_level (cfg_level),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx),
    .upd_level (upd_level),
    .req_nxt   (req_nxt),
    .bad_pin   (bad_pin)
  );

  // end-of-interrupt lookup
  trk_eoi_match #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_eoi (
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .cfg_vector (cfg_vector),
    .isr_cur    (isr_q),
    .isr_clr    (eoi_clr),
    .res        (eoi_res)
  );

  // next state
  always_comb begin
    isr_nxt               = (isr_q & ~eoi_clr) | (svc_onehot & cfg_level);
    flags_nxt.bad_pin     = bad_pin;
    flags_nxt.eoi_nomatch = (eoi_res == EOI_NOMATCH);
    flags_nxt.eoi_stale   = (eoi_res == EOI_STALE);
    req_we                = svc_done || bset_valid || bclr_valid || upd_valid;
    isr_we                = svc_done || eoi_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (req_we) begin
      req_q <= req_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else if (isr_we) begin
      isr_q <= isr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_nxt;
    end
  end

  // outputs
  assign dlv_valid   = cand_any && !sel_masked;
  assign dlv_pin     = sel;
  assign dlv_vector  = cfg_vector[sel*VEC_W +: VEC_W];
  assign dlv_level   = cfg_level[sel];
  assign req_vec     = req_q;
  assign isr_vec     = isr_q;
  assign pin_err     = flags_q.bad_pin;
  assign eoi_nomatch = flags_q.eoi_nomatch;
  assign eoi_stale   = flags_q.eoi_stale;

endmodule

// File: rtl/trk_checker.sv
`timescale 1ns/1ps
module trk_checker #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] cfg_mask,
  input logic                upd_valid,
  input logic [IDX_W-1:0]    upd_idx,
  input logic                dlv_ready,
  input logic                dlv_valid,
  input logic [IDX_W-1:0]    dlv_pin,
  input logic                dlv_level,
  input logic [NUM_PINS-1:0] req_vec,
  input logic [NUM_PINS-1:0] isr_vec,
  input logic                pin_err,
  input logic                eoi_nomatch,
  input logic                eoi_stale
);

  localparam logic [IDX_W:0] PIN_LIMIT = (IDX_W+1)'(NUM_PINS);

  AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> req_vec[dlv_pin]); // R5

  AST_OFFER_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (((req_vec & ~isr_vec) >> dlv_pin) == NUM_PINS'(1))); // R5

  AST_OFFER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !cfg_mask[dlv_pin]); // R6

  AST_OFFER_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !isr_vec[dlv_pin]); // R7

  AST_LEVEL_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && dlv_level) |=> isr_vec[$past(dlv_pin)]); // R6

  AST_BAD_PIN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && ({1'b0, upd_idx} >= PIN_LIMIT)) |=> pin_err); // R2

  AST_EOI_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoi_nomatch && eoi_stale)); // R9

endmodule

bind pin_req_tracker trk_checker #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_mask    (cfg_mask),
  .upd_valid   (upd_valid),
  .upd_idx     (upd_idx),
  .dlv_ready   (dlv_ready),
  .dlv_valid   (dlv_valid),
  .dlv_pin     (dlv_pin),
  .dlv_level   (dlv_level),
  .req_vec     (req_vec),
  .isr_vec     (isr_vec),
  .pin_err     (pin_err),
  .eoi_nomatch (eoi_nomatch),
  .eoi_stale   (eoi_stale)
);

// File: tb/sim_pin_req_tracker.sv
`timescale 1ns/1ps
module sim_pin_req_tracker;

  localparam int NP = 24;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [NP*VW-1:0] cfg_vec;
  logic [NP-1:0] cfg_mask, cfg_level;
  logic          upd_valid, upd_level;
  logic [4:0]    upd_idx;
  logic          bset_v, bclr_v;
  logic [15:0]   bset_m, bclr_m;
  logic          eoi_v;
  logic [7:0]    eoi_vec;
  logic          ready;

  logic          dlv_valid, dlv_level, pin_err, eoi_nomatch, eoi_stale;
  logic [4:0]    dlv_pin;
  logic [7:0]    dlv_vector;
  logic [NP-1:0] req_vec, isr_vec;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [NP-1:0] m_req, m_isr;
  logic          obs_valid;
  logic [4:0]    obs_pin;

  always #2 clk = ~clk;

  pin_req_tracker u0 (
    .clk(clk), .rst_n(rst_n), .ctl_enable(en),
    .cfg_vector(cfg_vec), .cfg_mask(cfg_mask), .cfg_level(cfg_level),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_level(upd_level),
    .bset_valid(bset_v), .bset_mask(bset_m),
    .bclr_valid(bclr_v), .bclr_mask(bclr_m),
    .eoi_valid(eoi_v), .eoi_vector(eoi_vec), .dlv_ready(ready),
    .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
    .dlv_level(dlv_level), .req_vec(req_vec), .isr_vec(isr_vec),
    .pin_err(pin_err), .eoi_nomatch(eoi_nomatch), .eoi_stale(eoi_stale)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int hi_bit(input logic [NP-1:0] v);
    int r = -1;
    for (int i = 0; i < NP; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int eoi_find(input logic [7:0] vec);
    for (int j = 0; j < NP-1; j++) if (cfg_vec[j*VW +: VW] == vec) return j;
    return -1;
  endfunction

  task automatic clr_pulses();
    upd_valid = 1'b0; bset_v = 1'b0; bclr_v = 1'b0; eoi_v = 1'b0;
  endtask

  // One clock: inputs already driven after a falling edge.
  task automatic cycle();
    int sel, hit;
    logic ev, done, e_bad, e_nm, e_st;
    logic [NP-1:0] nr, ni;
    #1;
    sel  = hi_bit(m_req & ~m_isr);
    ev   = (sel >= 0) && !cfg_mask[sel];
    done = (sel >= 0) && (cfg_mask[sel] || ready);
    obs_valid = dlv_valid;
    obs_pin   = dlv_pin;
    chk("R5 offer valid", 32'(dlv_valid), 32'(ev));
    if (ev) begin
      chk("R5 offer pin", 32'(dlv_pin), 32'(sel));
      chk("R5 offer vector", 32'(dlv_vector), 32'(cfg_vec[sel*VW +: VW]));
      chk("R5 offer level", 32'(dlv_level), 32'(cfg_level[sel]));
    end
    nr = m_req;
    if (done) nr[sel] = 1'b0;
    if (bset_v) nr = nr | {8'b0, bset_m};
    if (bclr_v) nr = nr & ~{8'b0, bclr_m};
    e_bad = upd_valid && (int'(upd_idx) >= NP);
    if (upd_valid && !e_bad && en && !cfg_mask[upd_idx]) begin
      if (cfg_level[upd_idx]) nr[upd_idx] = upd_level;
      else if (upd_level) nr[upd_idx] = 1'b1;
    end
    hit  = eoi_find(eoi_vec);
    e_nm = eoi_v && (hit < 0);
    e_st = eoi_v && (hit >= 0) && !m_isr[hit];
    ni = m_isr;
    if (eoi_v && hit >= 0) ni[hit] = 1'b0;
    if (done && cfg_level[sel]) ni[sel] = 1'b1;
    @(posedge clk); #1;
    chk("R3 request vector", 32'(req_vec), 32'(nr));
    chk("R7 in-service vector", 32'(isr_vec), 32'(ni));
    chk("R2 pin_err", 32'(pin_err), 32'(e_bad));
    chk("R9 eoi_nomatch", 32'(eoi_nomatch), 32'(e_nm));
    chk("R9 eoi_stale", 32'(eoi_stale), 32'(e_st));
    m_req = nr;
    m_isr = ni;
    @(negedge clk);
    clr_pulses();
  endtask

  task automatic pin_upd(input int idx, input logic lvl);
    upd_valid = 1'b1; upd_idx = 5'(idx); upd_level = lvl;
    cycle();
  endtask

  task automatic do_eoi(input logic [7:0] v);
    eoi_v = 1'b1; eoi_vec = v;
    cycle();
  endtask

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog expired");
    n_errors++;
    if (!finished) begin
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; en = 1'b1; ready = 1'b0;
    for (int i = 0; i < NP; i++) cfg_vec[i*VW +: VW] = 8'(8'h30 + i);
    cfg_mask = '0; cfg_level = 24'h00F0F0;
    upd_idx = '0; upd_level = 1'b0; bset_m = '0; bclr_m = '0; eoi_vec = '0;
    clr_pulses();
    m_req = '0; m_isr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 reset req", 32'(req_vec), 32'd0);
    chk("R11 reset isr", 32'(isr_vec), 32'd0);
    chk("R11 reset offer", 32'(dlv_valid), 32'd0);
    chk("R11 reset flags", 32'({pin_err, eoi_nomatch, eoi_stale}), 32'd0);
    @(negedge clk);

    // R1: disabled, then masked
    en = 1'b0; pin_upd(2, 1'b1);
    chk("R1 disabled update ignored", 32'(req_vec[2]), 32'd0);
    en = 1'b1; cfg_mask[2] = 1'b1; pin_upd(2, 1'b1);
    chk("R1 masked update ignored", 32'(req_vec[2]), 32'd0);
    cfg_mask[2] = 1'b0;

    // R2: bad index
    pin_upd(27, 1'b1);
    chk("R2 bad index flag", 32'(pin_err), 32'd1);
    chk("R2 bad index no change", 32'(req_vec), 32'd0);

    // R3: edge and level behaviour, delivery stalled
    pin_upd(2, 1'b1);
    pin_upd(2, 1'b0);
    chk("R3 edge low keeps request", 32'(req_vec[2]), 32'd1);
    pin_upd(5, 1'b1);
    chk("R3 level high sets", 32'(req_vec[5]), 32'd1);
    pin_upd(5, 1'b0);
    chk("R3 level low clears", 32'(req_vec[5]), 32'd0);
    ready = 1'b1; cycle();
    chk("R6 accepted pin", 32'(obs_pin), 32'd2);
    chk("R6 request cleared", 32'(req_vec[2]), 32'd0);
    ready = 1'b0;

    // R10: same-cycle ordering
    bset_v = 1'b1; bset_m = 16'h0003; bclr_v = 1'b1; bclr_m = 16'h0001;
    upd_valid = 1'b1; upd_idx = 5'd0; upd_level = 1'b1;
    cycle();
    chk("R10 single after clear", 32'(req_vec[1:0]), 32'd3);
    bset_v = 1'b1; bset_m = 16'h0004; bclr_v = 1'b1; bclr_m = 16'h0004;
    cycle();
    chk("R10 clear after set", 32'(req_vec[2]), 32'd0);
    bclr_v = 1'b1; bclr_m = 16'hFFFF; cycle();

    // R4 and R6: bulk ignores enable and mask; masked candidate dropped
    en = 1'b0; cfg_mask[9] = 1'b1;
    bset_v = 1'b1; bset_m = 16'h0200; cycle();
    chk("R4 bulk set while disabled and masked", 32'(req_vec[9]), 32'd1);
    cycle();
    chk("R6 masked candidate not offered", 32'(obs_valid), 32'd0);
    chk("R6 masked candidate dropped", 32'(req_vec[9]), 32'd0);
    en = 1'b1; cfg_mask[9] = 1'b0;

    // R5: highest first
    ready = 1'b1;
    bset_v = 1'b1; bset_m = 16'h0B04; cycle();
    cycle(); chk("R5 order 1st", 32'(obs_pin), 32'd11);
    cycle(); chk("R5 order 2nd", 32'(obs_pin), 32'd9);
    cycle(); chk("R5 order 3rd", 32'(obs_pin), 32'd8);
    cycle(); chk("R5 order 4th", 32'(obs_pin), 32'd2);
    cycle(); chk("R5 drained", 32'(obs_valid), 32'd0);

    // R7: level pin blocked until end-of-interrupt
    pin_upd(13, 1'b1);
    cycle();
    chk("R6 level enters service", 32'(isr_vec[13]), 32'd1);
    pin_upd(13, 1'b1);
    do_eoi(8'h3D);
    chk("R7 blocked while in service", 32'(obs_valid), 32'd0);
    chk("R8 eoi clears service", 32'(isr_vec[13]), 32'd0);
    cycle();
    chk("R7 offered after eoi", 32'(obs_valid && obs_pin == 5'd13), 32'd1);
    do_eoi(8'h3D);

    // R8/R9: duplicate vector, first match wins; pin 23 excluded
    cfg_vec[12*VW +: VW] = 8'h50; cfg_vec[14*VW +: VW] = 8'h50;
    pin_upd(14, 1'b1);
    cycle();
    do_eoi(8'h50);
    chk("R9 stale flag", 32'(eoi_stale), 32'd1);
    chk("R8 first match only", 32'(isr_vec[14]), 32'd1);
    pin_upd(12, 1'b1);
    cycle();
    do_eoi(8'h50);
    chk("R8 matched pin cleared", 32'(isr_vec[12]), 32'd0);
    cfg_vec[23*VW +: VW] = 8'hEE;
    do_eoi(8'hEE);
    chk("R9 nomatch for pin 23 vector", 32'(eoi_nomatch), 32'd1);

    // random traffic against the model
    for (int i = 0; i < NP; i++) cfg_vec[i*VW +: VW] = 8'($urandom_range(16, 60));
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 99) < 3) begin
        cfg_mask  = 24'($urandom) & 24'($urandom) & 24'($urandom);
        cfg_level = 24'($urandom);
      end
      en        = ($urandom_range(0, 9) != 0);
      ready     = ($urandom_range(0, 2) != 0);
      upd_valid = ($urandom_range(0, 2) == 0);
      upd_idx   = 5'($urandom_range(0, 31));
      upd_level = 1'($urandom_range(0, 1));
      bset_v    = ($urandom_range(0, 7) == 0);
      bset_m    = 16'($urandom);
      bclr_v    = ($urandom_range(0, 7) == 0);
      bclr_m    = 16'($urandom);
      eoi_v     = ($urandom_range(0, 3) == 0);
      eoi_vec   = 8'($urandom_range(16, 64));
      cycle();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule